// File: doc/BRIEF.md
# I2C Bus Status Flag Monitor

This block observes the clock and data lines of an I2C bus and keeps a set of status flags for a controller that sits beside it. It recognises start and stop conditions and counts SCL rising edges within each byte, which lets it find the acknowledge clock (the ninth) and the first clock of the following byte. Three sticky flags (acknowledge seen, start seen, stop seen) and a bus-busy bit are set by bus events. Each flag is cleared by its own set of bus positions and control changes, so these are not flags that clear when read.

A small flag register holds two configuration bits that software may change only while the monitor is disabled. It also shows two read-only bits: the bus-busy state and a start-clear indication. The start-clear indication always reads 0 here because the block never generates start conditions. The monitor does not drive the bus, shift data, generate clocks or arbitrate. The raw line levels pass through an internal two-stage synchronizer before any event is decoded.

Top module: `i2c_flag_monitor`

## Requirements
- R1: After reset every flag and the bus-busy bit are 0 and the flag register reads 0x00. On any clock edge at which `enable_i` is 0, the acknowledge, start, stop and busy flags are forced to 0.
- R2: SDA falling while SCL stays high is a start condition. It sets the start flag and the bus-busy bit.
- R3: SDA rising while SCL stays high is a stop condition. It sets the stop flag and clears the acknowledge flag, the start flag and the bus-busy bit.
- R4: At the ninth SCL rising edge of a byte, the acknowledge flag sets if SDA is low at that edge. If SDA is high there, the flag stays 0.
- R5: The acknowledge flag clears at the first SCL rising edge of the next byte, which is the tenth rising edge after the byte began.
- R6: The start flag stays set for all nine clocks of the address byte. It clears at the first SCL rising edge of the byte that follows.
- R7: The stop flag is not cleared by a start condition alone. It clears at the first SCL rising edge after a start condition.
- R8: A repeated start resets the in-byte clock count, so the ninth clock is counted from the repeated start.
- R9: A one-cycle `release_i` pulse clears the acknowledge and start flags. If it coincides with a start condition, the start flag stays 0 while the busy bit still sets.
- R10: A 1-to-0 change of `wakeup_i` clears the stop flag. If it coincides with a stop condition, the stop flag stays 0.
- R11: Flag register layout: bit 0 is reservation-enable and bit 1 is start-condition-enable, both writable only while `enable_i` is 0. Bit 6 is start-clear and reads 0. Bit 7 is bus-busy. Bits 5:2 read 0. Writes to bits 7:2 have no effect.
- R12: When `enable_i` rises, the bus-busy bit is loaded with the inverse of start-condition-enable (bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| enable_i | input | 1 | Monitor enable |
| release_i | input | 1 | One-cycle exit-from-communication command |
| wakeup_i | input | 1 | Wakeup mode bit |
| reg_we_i | input | 1 | Flag register write strobe |
| reg_wdata_i | input | 8 | Flag register write data |
| ack_det_o | output | 1 | Acknowledge detected flag |
| start_det_o | output | 1 | Start detected flag (address phase) |
| stop_det_o | output | 1 | Stop detected flag |
| bus_busy_o | output | 1 | Bus busy indicator |
| flag_reg_o | output | 8 | Readable flag register |

## Verification
Two pairs of functions can fall on the same clock edge: a control clear with a bus-event set. These are a release pulse on the edge that registers a start condition, and a fall of the wakeup bit on the edge that registers a stop condition. The bench schedules the control change two clock edges after it moves SDA, which is the edge at which the synchronized line change first produces the event. The outcome is judged at the ports: the start flag must stay 0 while the busy bit still sets, and the stop flag must stay 0 while the busy bit clears.

// File: rtl/ifm_pkg.sv
package ifm_pkg;

  // Decoded bus events, valid for one clock
  typedef struct packed {
    logic start;       // SDA fell while SCL high
    logic stop;        // SDA rose while SCL high
    logic ninth;       // ninth SCL rise of a byte
    logic first_next;  // first SCL rise of the following byte
    logic first_addr;  // first SCL rise after a start
  } bus_evt_t;

  localparam int unsigned REG_W         = 8;
  localparam int unsigned REG_RSV_BIT   = 0;
  localparam int unsigned REG_STCEN_BIT = 1;
  localparam int unsigned REG_STCLR_BIT = 6;
  localparam int unsigned REG_BUSY_BIT  = 7;

endpackage

// File: rtl/ifm_line_sync.sv
module ifm_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);

  localparam logic [STAGES-1:0] IDLE = {STAGES{1'b1}};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= IDLE;
      else        chain_q <= chain_d;
    end

    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ifm_bus_events.sv
module ifm_bus_events
  import ifm_pkg::*;
#(
  parameter int unsigned BYTE_BITS = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active_i,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  localparam int unsigned LAST  = BYTE_BITS + 1;
  localparam int unsigned CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST);

  logic             scl_p_q, sda_p_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             rise, start_c, stop_c;

  always_comb begin
    rise    = active_i & scl_i & ~scl_p_q;
    start_c = active_i & scl_i & scl_p_q & sda_p_q & ~sda_i;
    stop_c  = active_i & scl_i & scl_p_q & ~sda_p_q & sda_i;
  end

  // in-byte clock count and post-start arm
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (!active_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (start_c) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (rise) begin
      cnt_d   = (cnt_q == CNT_LAST) ? CNT_W'(1) : cnt_q + CNT_W'(1);
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      scl_p_q <= scl_i;
      sda_p_q <= sda_i;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    evt_o.start      = start_c;
    evt_o.stop       = stop_c;
    evt_o.ninth      = rise & (cnt_q == CNT_ACK);
    evt_o.first_next = rise & (cnt_q == CNT_LAST);
    evt_o.first_addr = rise & armed_q;
  end

endmodule

// File: rtl/ifm_status_flags.sv
module ifm_status_flags
  import ifm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable_i,
  input  logic     release_i,
  input  logic     wk_fall_i,
  input  logic     en_rise_i,
  input  logic     stcen_i,
  input  logic     sda_i,
  input  bus_evt_t evt_i,
  output logic     ack_o,
  output logic     start_o,
  output logic     stop_o,
  output logic     busy_o
);

  logic ack_q, start_q, stop_q, busy_q;
  logic ack_d, start_d, stop_d, busy_d;
  logic byte_clr;

  assign byte_clr = release_i | evt_i.stop | evt_i.first_next;

  // control clears take priority over bus-event sets
  always_comb begin
    ack_d   = ack_q;
    start_d = start_q;
    stop_d  = stop_q;
    busy_d  = busy_q;
    if (!enable_i) begin
      ack_d   = 1'b0;
      start_d = 1'b0;
      stop_d  = 1'b0;
      busy_d  = 1'b0;
    end else begin
      if (byte_clr)                     ack_d = 1'b0;
      else if (evt_i.ninth && !sda_i)   ack_d = 1'b1;

      if (byte_clr)                     start_d = 1'b0;
      else if (evt_i.start)             start_d = 1'b1;

      if (wk_fall_i || evt_i.first_addr) stop_d = 1'b0;
      else if (evt_i.stop)              stop_d = 1'b1;

      if (en_rise_i)                    busy_d = ~stcen_i;
      else if (evt_i.stop)              busy_d = 1'b0;
      else if (evt_i.start)             busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      ack_q   <= ack_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      busy_q  <= busy_d;
    end
  end

  assign ack_o   = ack_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign busy_o  = busy_q;

endmodule

// File: rtl/ifm_flag_reg.sv
module ifm_flag_reg
  import ifm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic             stcen_o,
  output logic [REG_W-1:0] rdata_o
);

  logic rsv_q, rsv_d, stcen_q, stcen_d, wr_en;
  logic unused_wdata;

  assign wr_en        = we_i & ~enable_i;
  assign unused_wdata = ^wdata_i;

  always_comb begin
    rsv_d   = rsv_q;
    stcen_d = stcen_q;
    if (wr_en) begin
      rsv_d   = wdata_i[REG_RSV_BIT];
      stcen_d = wdata_i[REG_STCEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_q   <= 1'b0;
      stcen_q <= 1'b0;
    end else begin
      rsv_q   <= rsv_d;
      stcen_q <= stcen_d;
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[REG_RSV_BIT]   = rsv_q;
    rdata_o[REG_STCEN_BIT] = stcen_q;
    rdata_o[REG_STCLR_BIT] = 1'b0;
    rdata_o[REG_BUSY_BIT]  = busy_i;
  end

  assign stcen_o = stcen_q;

endmodule

// File: rtl/i2c_flag_monitor.sv
module i2c_flag_monitor
  import ifm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_BITS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       enable_i,
  input  logic       release_i,
  input  logic       wakeup_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic       ack_det_o,
  output logic       start_det_o,
  output logic       stop_det_o,
  output logic       bus_busy_o,
  output logic [7:0] flag_reg_o
);

  logic [1:0] line_s;
  logic       en_q, wk_q;
  logic       active, en_rise, wk_fall, stcen;
  bus_evt_t   evt;

  ifm_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      wk_q <= 1'b0;
    end else begin
      en_q <= enable_i;
      wk_q <= wakeup_i;
    end
  end

  assign active  = enable_i & en_q;
  assign en_rise = enable_i & ~en_q;
  assign wk_fall = wk_q & ~wakeup_i;

  ifm_bus_events #(.BYTE_BITS(BYTE_BITS)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .scl_i    (line_s[1]),
    .sda_i    (line_s[0]),
    .evt_o    (evt)
  );

  ifm_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .release_i (release_i),
    .wk_fall_i (wk_fall),
    .en_rise_i (en_rise),
    .stcen_i   (stcen),
    .sda_i     (line_s[0]),
    .evt_i     (evt),
    .ack_o     (ack_det_o),
    .start_o   (start_det_o),
    .stop_o    (stop_det_o),
    .busy_o    (bus_busy_o)
  );

  ifm_flag_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .busy_i   (bus_busy_o),
    .stcen_o  (stcen),
    .rdata_o  (flag_reg_o)
  );

endmodule

// File: rtl/ifm_checker.sv
module ifm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable_i,
  input logic       release_i,
  input logic       wakeup_i,
  input logic       reg_we_i,
  input logic       ack_det_o,
  input logic       start_det_o,
  input logic       stop_det_o,
  input logic       bus_busy_o,
  input logic [7:0] flag_reg_o
);

  a_r1_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!ack_det_o && !start_det_o && !stop_det_o && !bus_busy_o));

  a_r2_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_det_o) |-> bus_busy_o);

  a_r3_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_det_o) |-> (!bus_busy_o && !start_det_o && !ack_det_o));

  a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (!ack_det_o && !start_det_o));

  a_r10_wake_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wakeup_i) |=> !stop_det_o);

  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && enable_i) |=> $stable(flag_reg_o[1:0]));

  a_r11_ro_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_reg_o[6:2] == 5'd0);

endmodule

bind i2c_flag_monitor ifm_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .release_i   (release_i),
  .wakeup_i    (wakeup_i),
  .reg_we_i    (reg_we_i),
  .ack_det_o   (ack_det_o),
  .start_det_o (start_det_o),
  .stop_det_o  (stop_det_o),
  .bus_busy_o  (bus_busy_o),
  .flag_reg_o  (flag_reg_o)
);

// File: tb/i2c_flag_monitor_bench.sv
`timescale 1ns/1ps
module i2c_flag_monitor_bench;

  logic       clk = 1'b0;
  logic       rst_n, scl_i, sda_i, enable_i, release_i, wakeup_i, reg_we_i;
  logic [7:0] reg_wdata_i;
  logic       ack_det_o, start_det_o, stop_det_o, bus_busy_o;
  logic [7:0] flag_reg_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  i2c_flag_monitor u_i2c_flag_monitor (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .enable_i(enable_i), .release_i(release_i), .wakeup_i(wakeup_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .ack_det_o(ack_det_o), .start_det_o(start_det_o), .stop_det_o(stop_det_o),
    .bus_busy_o(bus_busy_o), .flag_reg_o(flag_reg_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic scl, input logic sda);
    @(negedge clk);
    scl_i = scl;
    sda_i = sda;
    repeat (4) @(negedge clk);
  endtask

  task automatic rise_bit(input logic b);
    step(1'b0, b);
    step(1'b1, b);
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    reg_we_i = 1'b1;
    reg_wdata_i = v;
    @(negedge clk);
    reg_we_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk);
    enable_i = v;
    repeat (3) @(negedge clk);
  endtask

  // control change lands on the edge where the line change becomes an event
  task automatic collide(input logic new_sda, input bit use_wake);
    @(negedge clk);
    sda_i = new_sda;
    @(negedge clk);
    @(negedge clk);
    if (use_wake) wakeup_i = 1'b0;
    else          release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_i = 1'b1; sda_i = 1'b1; enable_i = 1'b0;
    release_i = 1'b0; wakeup_i = 1'b1; reg_we_i = 1'b0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 reset flags", {4'd0, ack_det_o, start_det_o, stop_det_o, bus_busy_o}, 8'h00);
    check("R1 reset reg", flag_reg_o, 8'h00);

    // R11 writes while disabled, read-only bits ignored
    write_reg(8'hFF);
    check("R11 write disabled", flag_reg_o, 8'h03);
    set_enable(1'b1);
    check("R12 stcen=1 busy", {7'd0, bus_busy_o}, 8'h00);
    write_reg(8'h00);
    check("R11 write while enabled ignored", flag_reg_o, 8'h03);
    set_enable(1'b0);
    write_reg(8'hFD);
    check("R11 write rsv only", flag_reg_o, 8'h01);
    set_enable(1'b1);
    check("R12 stcen=0 busy", flag_reg_o, 8'h81);

    // R3 stop from idle
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
    check("R3 stop flags", {4'd0, ack_det_o, start_det_o, stop_det_o, bus_busy_o}, 8'h02);

    // address byte with ack / nack, then a data byte, then stop
    for (int a = 0; a < 2; a++) begin
      step(1'b1, 1'b0);
      check("R2 start flag", {6'd0, start_det_o, bus_busy_o}, 8'h03);
      check("R7 stop kept over start", {7'd0, stop_det_o}, 8'h01);
      for (int k = 1; k <= 9; k++) begin
        logic b;
        b = (k == 9) ? a[0] : ((8'hA5 >> (8 - k)) & 8'h01) != 0;
        rise_bit(b);
        check("R4 ack after clock", {7'd0, ack_det_o}, {7'd0, (k == 9 && a == 0)});
        check("R6 start held in address byte", {7'd0, start_det_o}, 8'h01);
        if (k == 1) check("R7 stop cleared first clock", {7'd0, stop_det_o}, 8'h00);
      end
      rise_bit(1'b1);
      check("R5 ack cleared next byte", {7'd0, ack_det_o}, 8'h00);
      check("R6 start cleared next byte", {7'd0, start_det_o}, 8'h00);
      for (int k = 2; k <= 9; k++) begin
        rise_bit(k == 9 ? 1'b0 : 1'b1);
        check("R4 data ack", {7'd0, ack_det_o}, {7'd0, k == 9});
      end
      step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
      check("R3 stop after data", {4'd0, ack_det_o, start_det_o, stop_det_o, bus_busy_o}, 8'h02);
    end

    // R8 repeated start after p clocks restarts the count
    for (int p = 1; p <= 8; p += 3) begin
      step(1'b1, 1'b0);
      for (int k = 0; k < p; k++) rise_bit(1'b0);
      step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
      check("R8 restart start flag", {7'd0, start_det_o}, 8'h01);
      for (int k = 1; k <= 9; k++) begin
        rise_bit(1'b0);
        if (k >= 8) check("R8 ack counted from restart", {7'd0, ack_det_o}, {7'd0, k == 9});
      end
      step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
    end

    // R9 release clears ack and start
    step(1'b1, 1'b0);
    for (int k = 1; k <= 9; k++) rise_bit(1'b0);
    check("R9 before release", {6'd0, ack_det_o, start_det_o}, 8'h03);
    @(negedge clk); release_i = 1'b1;
    @(negedge clk); release_i = 1'b0;
    @(negedge clk);
    check("R9 release cleared", {6'd0, ack_det_o, start_det_o}, 8'h00);
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);

    // R9 release on the same edge as a start condition
    collide(1'b0, 1'b0);
    check("R9 start+release", {6'd0, start_det_o, bus_busy_o}, 8'h01);
    step(1'b1, 1'b1);

    // R10 wakeup fall on the same edge as a stop condition
    step(1'b1, 1'b0);
    rise_bit(1'b1);
    check("R10 stop clear before", {7'd0, stop_det_o}, 8'h00);
    step(1'b0, 1'b0); step(1'b1, 1'b0);
    collide(1'b1, 1'b1);
    check("R10 stop+wake fall", {6'd0, stop_det_o, bus_busy_o}, 8'h00);

    // R10 plain wakeup fall
    @(negedge clk); wakeup_i = 1'b1;
    step(1'b1, 1'b0); step(1'b1, 1'b1);
    check("R10 stop set", {7'd0, stop_det_o}, 8'h01);
    @(negedge clk); wakeup_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 wake fall clears stop", {7'd0, stop_det_o}, 8'h00);

    // R1 disable clears flags
    step(1'b1, 1'b0);
    for (int k = 1; k <= 9; k++) rise_bit(1'b0);
    set_enable(1'b0);
    check("R1 disabled flags", {4'd0, ack_det_o, start_det_o, stop_det_o, bus_busy_o}, 8'h00);
    check("R1 disabled reg", flag_reg_o, 8'h01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule